// File: doc/BRIEF.md
# Host Interrupt Threshold Controller

This block holds the command word and the interrupt-moderation logic of a USB 2.0 host controller. Software reaches it through a simple 32-bit register port with three word locations: command, status and interrupt enable. The command word selects how many microframes must pass between interrupts. It also carries a doorbell bit that software rings after it unlinks asynchronous schedule entries, and the enables for the asynchronous and periodic schedule engines.

A one-cycle microframe tick advances a threshold counter. When the counter reaches the selected interval, it produces a boundary. Status events are latched as soon as they arrive. The single interrupt line may only rise on a boundary, and only while a latched status bit has its enable set.

The doorbell is closed through a handshake with the schedule engine. While the doorbell is set, an eviction-complete pulse sets the async-advance status bit and clears the doorbell on the same clock edge.

Top module: `usb_irq_moderator`

## Requirements
- R1: The threshold field is command bits 23:16. The one-hot codes 01h, 02h, 04h, 08h, 10h, 20h and 40h give an interval of 1, 2, 4, 8, 16, 32 and 64 microframes. After a command write, the first boundary falls on the N-th tick, and a pending enabled status raises `irq` at the clock edge of that tick.
- R2: Any other threshold code, including 00h, 03h and FFh, behaves as an interval of 8 microframes. The written value still reads back unchanged.
- R3: After `rst_n` is asserted, the command word (address 0) reads 0008_0000h. Status (address 1) and enable (address 2) read 0. `irq`, `doorbell`, `async_en` and `periodic_en` are all 0.
- R4: Command bits 31:24, 15:7 and 3:0 always read 0, whatever was written to them.
- R5: Writing 1 to command bit 6 sets the doorbell. Writing 0 to bit 6 leaves it unchanged.
- R6: When `evict_done` is high while the doorbell is 1, the doorbell reads 0 and status bit 5 reads 1 after that same edge. When the doorbell is 0, `evict_done` changes nothing.
- R7: Status bit 0 latches `evt_xfer`, bit 1 latches `evt_err` and bit 5 latches the async-advance condition. Enable bits 0, 1 and 5 gate the matching status bit. A status bit whose enable is 0 never raises `irq`.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. `irq` stays high until no enabled status bit remains set, and it falls at the edge of the clearing write.
- R9: Every write to the command word restarts the microframe count, and a tick in that same cycle is not counted.
- R10: A command write with bit 1 set returns the command, status, enable, counter and `irq` to their reset values. The rest of that write is discarded, and bit 1 itself reads 0.
- R11: Command bit 5 drives `async_en` and bit 4 drives `periodic_en`. Both are read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low suspend-well reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word: 0 command, 1 status, 2 enable |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word select |
| rd_data | output | 32 | Read data (combinational) |
| mf_tick | input | 1 | One-cycle microframe pulse |
| evict_done | input | 1 | Schedule engine has dropped cached async state |
| evt_xfer | input | 1 | Transfer-complete event |
| evt_err | input | 1 | Transfer-error event |
| irq | output | 1 | Moderated interrupt |
| doorbell | output | 1 | Async-advance doorbell to the schedule engine |
| async_en | output | 1 | Asynchronous schedule enable |
| periodic_en | output | 1 | Periodic schedule enable |

## Verification
The hardest case to reach is the first interrupt for the 64-microframe code. It needs an enabled event that is already latched, followed by exactly sixty-four ticks counted from a fresh command write, with no stray write in between that would restart the count. The bench table walks every threshold code in this way: it writes the code, latches one event, and then pulses ticks one at a time, recording on which tick `irq` rises. A second, less obvious case is the handshake edge itself. The bench samples right after the single `evict_done` cycle and expects the doorbell cleared and the status bit set in that same sample.

// File: rtl/usb_irq_moderator.sv
module usb_irq_moderator #(
  parameter int DW = 32,
  parameter int AW = 2,
  parameter logic [7:0] THR_RESET = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          mf_tick,
  input  logic          evict_done,
  input  logic          evt_xfer,
  input  logic          evt_err,
  output logic          irq,
  output logic          doorbell,
  output logic          async_en,
  output logic          periodic_en
);
  localparam int CNTW = 7;

  logic [7:0]      thr_q;
  logic            db_q, ase_q, pse_q;
  logic [2:0]      sts_q, en_q;
  logic [CNTW-1:0] cnt_q;
  logic            irq_q;

  logic [CNTW-1:0] interval, cnt_n;
  logic [2:0]      sts_n, en_n, w1c;
  logic            boundary, aa_set, any_n, irq_n, db_n;

  wire wr_cmd = wr_en && (wr_addr == AW'(0));
  wire wr_sts = wr_en && (wr_addr == AW'(1));
  wire wr_ena = wr_en && (wr_addr == AW'(2));
  wire hc_rst = wr_cmd && wr_data[1];

  always_comb begin
    case (thr_q)
      8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40: interval = thr_q[CNTW-1:0];
      default: interval = CNTW'(8);
    endcase
  end

  assign boundary = mf_tick && !wr_cmd && (cnt_q == interval - CNTW'(1));

  always_comb begin
    if (wr_cmd)        cnt_n = '0;
    else if (boundary) cnt_n = '0;
    else if (mf_tick)  cnt_n = cnt_q + CNTW'(1);
    else               cnt_n = cnt_q;
  end

  assign aa_set = db_q && evict_done;
  assign db_n   = (db_q && !evict_done) || (wr_cmd && wr_data[6]);
  assign w1c    = wr_sts ? {wr_data[5], wr_data[1], wr_data[0]} : 3'b000;
  assign sts_n  = (sts_q & ~w1c) | {aa_set, evt_err, evt_xfer};
  assign en_n   = wr_ena ? {wr_data[5], wr_data[1], wr_data[0]} : en_q;
  assign any_n  = |(sts_n & en_n);
  assign irq_n  = any_n && (irq_q || boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_RESET;
      db_q  <= 1'b0;
      ase_q <= 1'b0;
      pse_q <= 1'b0;
      sts_q <= '0;
      en_q  <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (hc_rst) begin
      thr_q <= THR_RESET;
      db_q  <= 1'b0;
      ase_q <= 1'b0;
      pse_q <= 1'b0;
      sts_q <= '0;
      en_q  <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        thr_q <= wr_data[23:16];
        ase_q <= wr_data[5];
        pse_q <= wr_data[4];
      end
      db_q  <= db_n;
      sts_q <= sts_n;
      en_q  <= en_n;
      cnt_q <= cnt_n;
      irq_q <= irq_n;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(0): begin
        rd_data[23:16] = thr_q;
        rd_data[6]     = db_q;
        rd_data[5]     = ase_q;
        rd_data[4]     = pse_q;
      end
      AW'(1): begin
        rd_data[5] = sts_q[2];
        rd_data[1] = sts_q[1];
        rd_data[0] = sts_q[0];
      end
      AW'(2): begin
        rd_data[5] = en_q[2];
        rd_data[1] = en_q[1];
        rd_data[0] = en_q[0];
      end
      default: rd_data = '0;
    endcase
  end

  assign irq         = irq_q;
  assign doorbell    = db_q;
  assign async_en    = ase_q;
  assign periodic_en = pse_q;
endmodule

module usb_irq_moderator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [31:0] wr_data,
  input logic       mf_tick,
  input logic       evict_done,
  input logic       irq,
  input logic       doorbell,
  input logic [2:0] sts_q,
  input logic [2:0] en_q,
  input logic [6:0] cnt_q,
  input logic [6:0] interval
);
  wire cmd_wr = wr_en && (wr_addr == 2'd0);

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(sts_q & en_q))); // R7

  AST_IRQ_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mf_tick) && !$past(cmd_wr)); // R1

  AST_DOORBELL_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell && evict_done && !cmd_wr) |=> (!doorbell && sts_q[2])); // R6

  AST_DOORBELL_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doorbell) |-> $past(cmd_wr && wr_data[6] && !wr_data[1])); // R5

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < interval); // R9
endmodule

bind usb_irq_moderator usb_irq_moderator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mf_tick(mf_tick), .evict_done(evict_done), .irq(irq), .doorbell(doorbell),
  .sts_q(sts_q), .en_q(en_q), .cnt_q(cnt_q), .interval(interval)
);

// File: tb/usb_irq_moderator_test.sv
module usb_irq_moderator_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic mf_tick = 1'b0, evict_done = 1'b0, evt_xfer = 1'b0, evt_err = 1'b0;
  logic irq, doorbell, async_en, periodic_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_irq_moderator uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mf_tick(mf_tick), .evict_done(evict_done),
    .evt_xfer(evt_xfer), .evt_err(evt_err), .irq(irq), .doorbell(doorbell),
    .async_en(async_en), .periodic_en(periodic_en)
  );

  localparam int NV = 10;
  localparam logic [7:0] CODE [NV] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h00, 8'h03, 8'hFF};
  localparam int EXPN [NV] = '{1, 2, 4, 8, 16, 32, 64, 8, 8, 8};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic tick();
    @(negedge clk);
    mf_tick = 1'b1;
    @(negedge clk);
    mf_tick = 1'b0;
  endtask

  task automatic pulse_xfer();
    @(negedge clk);
    evt_xfer = 1'b1;
    @(negedge clk);
    evt_xfer = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); check("R3 cmd reset", v, 32'h0008_0000);
    rd(2'd1, v); check("R3 status reset", v, 32'h0);
    rd(2'd2, v); check("R3 enable reset", v, 32'h0);
    check("R3 outputs reset", {irq, doorbell, async_en, periodic_en}, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 32'h0000_0002);
      wr(2'd2, 32'h0000_0001);
      wr(2'd0, {8'h00, CODE[i], 16'h0000});
      pulse_xfer();
      first = 0;
      for (int k = 1; k <= 80; k++) begin
        tick();
        if (irq && first == 0) first = k;
      end
      check($sformatf("R1/R2 interval code %h", CODE[i]), first, EXPN[i]);
      rd(2'd0, v); check("R2 code reads back", v[23:16], CODE[i]);
      wr(2'd1, 32'h0000_0001);
      check("R8 irq falls after W1C", irq, 1'b0);
    end

    wr(2'd0, 32'h0000_0002);
    wr(2'd0, 32'hFFFF_FFFD);
    rd(2'd0, v); check("R4 reserved bits read zero", v, 32'h00FF_0070);
    check("R11 schedule enables", {async_en, periodic_en}, 2'b11);
    check("R5 doorbell set", doorbell, 1'b1);
    wr(2'd0, 32'h0008_0010);
    check("R5 write 0 keeps doorbell", doorbell, 1'b1);
    check("R11 async off periodic on", {async_en, periodic_en}, 2'b01);
    @(negedge clk);
    evict_done = 1'b1;
    @(negedge clk);
    evict_done = 1'b0;
    rd(2'd1, v);
    check("R6 same-edge doorbell clear", doorbell, 1'b0);
    check("R6 same-edge status set", v[5], 1'b1);

    for (int k = 0; k < 8; k++) tick();
    check("R7 disabled aa no irq", irq, 1'b0);
    wr(2'd2, 32'h0000_0020);
    check("R7 enable alone no irq", irq, 1'b0);
    for (int k = 0; k < 8; k++) tick();
    check("R7 aa irq at boundary", irq, 1'b1);
    wr(2'd1, 32'h0000_0001);
    check("R8 write other bit keeps irq", irq, 1'b1);
    wr(2'd1, 32'h0000_0020);
    rd(2'd1, v); check("R8 aa cleared", v, 32'h0);
    check("R8 irq released", irq, 1'b0);

    @(negedge clk);
    evict_done = 1'b1;
    @(negedge clk);
    evict_done = 1'b0;
    rd(2'd1, v); check("R6 evict ignored when idle", v, 32'h0);

    wr(2'd0, 32'h0000_0002);
    wr(2'd2, 32'h0000_0002);
    wr(2'd0, 32'h0004_0000);
    @(negedge clk); evt_err = 1'b1;
    @(negedge clk); evt_err = 1'b0;
    tick(); tick();
    wr(2'd0, 32'h0004_0000);
    tick(); tick(); tick();
    check("R9 restart no early irq", irq, 1'b0);
    tick();
    check("R9 irq after full interval", irq, 1'b1);

    wr(2'd0, 32'h0004_0072);
    rd(2'd0, v); check("R10 cmd back to reset", v, 32'h0008_0000);
    rd(2'd1, v); check("R10 status cleared", v, 32'h0);
    rd(2'd2, v); check("R10 enable cleared", v, 32'h0);
    check("R10 outputs cleared", {irq, doorbell, async_en, periodic_en}, 4'b0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule